// File: doc/BRIEF.md
# Asymmetric Three-Slot Decode Steering

This block sits between an instruction queue and a row of three instruction decoders. The queue has already found where each instruction begins and ends. It presents its oldest three entries, each with a valid bit, an opaque tag and a count of the micro-operations that instruction will produce.

The decoders differ in what they can handle. Slot 0 translates any instruction. Slots 1 and 2 translate only instructions that yield exactly one micro-operation. Each cycle the block takes the longest run of entries, in program order, that fits the slots. That run is the decode group. The block issues the group into a registered issue stage and tells the queue how many entries to pop. An instruction that needs several micro-operations and would fall into slot 1 or 2 closes the group. That instruction then opens the next cycle's group in slot 0.

Translation itself is modelled only by passing each tag and its micro-operation count through to the slot that received it. The decoder side uses a valid/ready handshake. The issue register holds a group while `dec_valid[0]` is high and `dec_ready` is low, and nothing is popped from the queue during that time. An empty issue register always accepts a new group, whatever `dec_ready` says. The queue side is a pop count, not a handshake: the queue must drop exactly `q_pop` entries at the clock edge.

Top module: `dec_steer`

## Requirements
- R1: After reset, every bit of `dec_valid` is 0.
- R2: When queue entry 0 is valid and a group is accepted, slot 0 receives entry 0 whatever its micro-operation count (0 to the field maximum).
- R3: Slots 1 and 2 only ever hold an instruction whose micro-operation field equals 1. A field value of 0 or of 2 and above counts as not simple.
- R4: Slot i receives entry i of the queue head, so program order runs from slot 0 to slot 2. Its tag and micro-operation count come out unchanged.
- R5: The group ends before the first entry that is invalid, or that sits in slot 1 or 2 and is not simple. Entries after that point are not issued, even when they are valid and simple.
- R6: A group is accepted when `dec_valid[0]` is 0 or `dec_ready` is 1. In that cycle `q_pop` equals the size of the group, from 0 to 3.
- R7: While `dec_valid[0]` is 1 and `dec_ready` is 0, `q_pop` is 0 and all `dec_*` outputs stay unchanged.
- R8: An accepted group appears on the `dec_*` outputs right after the clock edge at which it was accepted.
- R9: `dec_valid` is always a prefix: a set bit i implies that every bit below i is set.
- R10: When queue entry 0 is invalid and a group is accepted, `q_pop` is 0 and all of `dec_valid` is 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_valid | input | 3 | Valid bit of each head entry; bit 0 is the oldest |
| q_tag | input | 3*TAG_W | Tag of each head entry; entry i sits in bits [i*TAG_W +: TAG_W] |
| q_uops | input | 3*UOP_W | Micro-operation count of each entry, packed like q_tag |
| q_pop | output | 2 | Number of entries the queue drops at this edge |
| dec_valid | output | 3 | Per-slot issue valid |
| dec_tag | output | 3*TAG_W | Tag issued to each slot |
| dec_uops | output | 3*UOP_W | Micro-operation count issued to each slot |
| dec_ready | input | 1 | Decoders accept the held group at this edge |

## Verification
`q_pop` depends combinationally on the current queue head and handshake, so the bench drives inputs on the falling edge and reads `q_pop` one time step later, in the same cycle. The slot outputs pass through one register. The bench therefore compares them with the group it predicted for that vector at the next falling edge, after exactly one rising edge. Every combination of valid bits and 2-bit micro-operation counts is swept this way. Stall behaviour is then checked across several held cycles, before release, and with an empty issue register.

// File: rtl/dec_steer_pkg.sv
package dec_steer_pkg;

  typedef enum logic {
    CLS_SINGLE = 1'b0,
    CLS_MULTI  = 1'b1
  } insn_cls_e;

  localparam int unsigned SINGLE_UOP = 1;

endpackage

// File: rtl/dec_steer_classify.sv
module dec_steer_classify
  import dec_steer_pkg::*;
#(
  parameter int unsigned SLOTS    = 3,
  parameter int unsigned UOP_W    = 3,
  parameter logic [SLOTS-1:0] CAP_MULTI = 3'b001
) (
  input  logic [SLOTS-1:0]       ent_valid,
  input  logic [SLOTS*UOP_W-1:0] ent_uops,
  output logic [SLOTS-1:0]       ent_fits
);

  insn_cls_e cls [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_ent
    always_comb begin
      if (ent_uops[i*UOP_W +: UOP_W] == UOP_W'(SINGLE_UOP))
        cls[i] = CLS_SINGLE;
      else
        cls[i] = CLS_MULTI;
    end
    // a slot fits its entry if it can take multi-uop work or the entry is single
    assign ent_fits[i] = ent_valid[i] && (CAP_MULTI[i] || (cls[i] == CLS_SINGLE));
  end

endmodule

// File: rtl/dec_steer_group.sv
module dec_steer_group #(
  parameter int unsigned SLOTS = 3,
  localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0] ent_fits,
  output logic [SLOTS-1:0] grp_take,
  output logic [CNT_W-1:0] grp_size
);

  for (genvar i = 0; i < SLOTS; i++) begin : g_pre
    if (i == 0) begin : g_head
      assign grp_take[i] = ent_fits[i];
    end else begin : g_tail
      assign grp_take[i] = grp_take[i-1] && ent_fits[i];
    end
  end

  always_comb begin
    grp_size = '0;
    for (int i = 0; i < SLOTS; i++)
      grp_size = grp_size + CNT_W'(grp_take[i]);
  end

endmodule

// File: rtl/dec_steer_issue.sv
module dec_steer_issue #(
  parameter int unsigned SLOTS = 3,
  parameter int unsigned TAG_W = 8,
  parameter int unsigned UOP_W = 3,
  parameter logic [SLOTS-1:0] CAP_MULTI = 3'b001
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   ready,
  input  logic [SLOTS-1:0]       grp_take,
  input  logic [SLOTS*TAG_W-1:0] grp_tag,
  input  logic [SLOTS*UOP_W-1:0] grp_uops,
  output logic [SLOTS-1:0]       iss_valid,
  output logic [SLOTS*TAG_W-1:0] iss_tag,
  output logic [SLOTS*UOP_W-1:0] iss_uops
);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        iss_valid[i]                 <= 1'b0;
        iss_tag[i*TAG_W +: TAG_W]    <= '0;
        iss_uops[i*UOP_W +: UOP_W]   <= '0;
      end else if (load) begin
        iss_valid[i]                 <= grp_take[i];
        iss_tag[i*TAG_W +: TAG_W]    <= grp_take[i] ? grp_tag[i*TAG_W +: TAG_W] : '0;
        iss_uops[i*UOP_W +: UOP_W]   <= grp_take[i] ? grp_uops[i*UOP_W +: UOP_W] : '0;
      end
    end

    if (!CAP_MULTI[i]) begin : g_side_chk
      AST_SIDE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[i] |-> (iss_uops[i*UOP_W +: UOP_W] == UOP_W'(1))); // R3
    end
    if (i > 0) begin : g_prefix_chk
      AST_VALID_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[i] |-> iss_valid[i-1]); // R9
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid[0] && !ready) |=> ($stable(iss_valid) && $stable(iss_tag) && $stable(iss_uops))); // R7

endmodule

// File: rtl/dec_steer.sv
module dec_steer #(
  parameter int unsigned TAG_W = 8,
  parameter int unsigned UOP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       q_valid,
  input  logic [3*TAG_W-1:0] q_tag,
  input  logic [3*UOP_W-1:0] q_uops,
  output logic [1:0]       q_pop,
  output logic [2:0]       dec_valid,
  output logic [3*TAG_W-1:0] dec_tag,
  output logic [3*UOP_W-1:0] dec_uops,
  input  logic             dec_ready
);

  localparam int unsigned SLOTS = 3;
  localparam int unsigned CNT_W = $clog2(SLOTS + 1);
  localparam logic [SLOTS-1:0] CAP_MULTI = 3'b001;

  logic [SLOTS-1:0] fits;
  logic [SLOTS-1:0] take;
  logic [CNT_W-1:0] size;
  logic             load;

  dec_steer_classify #(
    .SLOTS(SLOTS), .UOP_W(UOP_W), .CAP_MULTI(CAP_MULTI)
  ) u_classify (
    .ent_valid(q_valid),
    .ent_uops (q_uops),
    .ent_fits (fits)
  );

  dec_steer_group #(.SLOTS(SLOTS)) u_group (
    .ent_fits(fits),
    .grp_take(take),
    .grp_size(size)
  );

  assign load  = !dec_valid[0] || dec_ready;
  assign q_pop = load ? size : '0;

  dec_steer_issue #(
    .SLOTS(SLOTS), .TAG_W(TAG_W), .UOP_W(UOP_W), .CAP_MULTI(CAP_MULTI)
  ) u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .ready    (dec_ready),
    .grp_take (take),
    .grp_tag  (q_tag),
    .grp_uops (q_uops),
    .iss_valid(dec_valid),
    .iss_tag  (dec_tag),
    .iss_uops (dec_uops)
  );

  AST_NO_POP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid[0] && !dec_ready) |-> (q_pop == '0)); // R7
  AST_POP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_valid[0] || dec_ready) |=> ($countones(dec_valid) == int'($past(q_pop)))); // R6
  AST_EMPTY_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid[0] |-> (q_pop == '0)); // R10
  AST_POP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop != '0) |-> q_valid[0]); // R2

endmodule

// File: tb/dec_steer_bench.sv
module dec_steer_bench;
  localparam int CLK_P = 10;
  localparam int TW = 8;
  localparam int UW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] qv = '0;
  logic [3*TW-1:0] qt = '0;
  logic [3*UW-1:0] qu = '0;
  logic [1:0] q_pop;
  logic [2:0] dv;
  logic [3*TW-1:0] dt;
  logic [3*UW-1:0] du;
  logic rdy = 1'b1;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dec_steer #(.TAG_W(TW), .UOP_W(UW)) u_dec_steer (
    .clk(clk), .rst_n(rst_n), .q_valid(qv), .q_tag(qt), .q_uops(qu),
    .q_pop(q_pop), .dec_valid(dv), .dec_tag(dt), .dec_uops(du), .dec_ready(rdy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int grp_cnt(input logic [2:0] v, input logic [3*UW-1:0] u);
    int c = 0;
    if (v[0]) c = 1;
    if (c == 1 && v[1] && u[UW +: UW] == UW'(1)) c = 2;
    if (c == 2 && v[2] && u[2*UW +: UW] == UW'(1)) c = 3;
    return c;
  endfunction

  task automatic set_vec(input int n);
    qv = {n[6], n[3], n[0]};
    qu = {n[8:7], n[5:4], n[2:1]};
    for (int k = 0; k < 3; k++) qt[k*TW +: TW] = {2'(k), 6'(n)} ^ 8'h5A;
  endtask

  // compare slot outputs with the group predicted from given inputs
  task automatic chk_out(input int c, input logic [3*TW-1:0] et, input logic [3*UW-1:0] eu);
    for (int k = 0; k < 3; k++) begin
      chk(dv[k] == (k < c), "R5/R9 slot valid", int'(dv[k]), int'(k < c));
      if (k < c) begin
        chk(dt[k*TW +: TW] == et[k*TW +: TW], "R4 tag", int'(dt[k*TW +: TW]), int'(et[k*TW +: TW]));
        chk(du[k*UW +: UW] == eu[k*UW +: UW], k == 0 ? "R2 slot0 uops" : "R3 side uops",
            int'(du[k*UW +: UW]), int'(eu[k*UW +: UW]));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3*TW-1:0] at, ht;
    logic [3*UW-1:0] hu;
    int c, hc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(dv == 3'b000, "R1 reset valid", int'(dv), 0);

    // exhaustive sweep with ready held high
    for (int n = 0; n < 512; n++) begin
      set_vec(n);
      c = grp_cnt(qv, qu);
      #1;
      chk(int'(q_pop) == c, "R6 pop count", int'(q_pop), c);
      if (!qv[0]) chk(q_pop == 2'd0, "R10 empty head pop", int'(q_pop), 0);
      at = qt; hu = qu;
      @(negedge clk);
      chk_out(c, at, hu);
      if (!qv[0]) chk(dv == 3'b000, "R10 bubble", int'(dv), 0);
    end

    // stall: load a full group then hold it
    set_vec(9'b0_01_0_01_0_01 | 9'b001001001);
    qv = 3'b111; qu = {2'd1, 2'd1, 2'd3};
    hc = grp_cnt(qv, qu); ht = qt; hu = qu;
    @(negedge clk);
    chk_out(hc, ht, hu);
    rdy = 1'b0;
    set_vec(200);
    qv = 3'b011; qu = {2'd1, 2'd1, 2'd2};
    c = grp_cnt(qv, qu); at = qt;
    for (int r = 0; r < 3; r++) begin
      #1;
      chk(q_pop == 2'd0, "R7 no pop on stall", int'(q_pop), 0);
      @(negedge clk);
      chk_out(hc, ht, hu);
    end
    rdy = 1'b1;
    #1;
    chk(int'(q_pop) == c, "R6 pop on release", int'(q_pop), c);
    hu = qu;
    @(negedge clk);
    chk_out(c, at, hu); // R8

    // empty head bubble
    qv = 3'b000;
    #1;
    chk(q_pop == 2'd0, "R10 empty pop", int'(q_pop), 0);
    @(negedge clk);
    chk(dv == 3'b000, "R10 empty issue", int'(dv), 0);

    // empty register accepts even with ready low
    rdy = 1'b0;
    set_vec(77);
    qv = 3'b111; qu = {2'd1, 2'd0, 2'd1};
    c = grp_cnt(qv, qu); at = qt; hu = qu;
    #1;
    chk(int'(q_pop) == c, "R6 accept while empty", int'(q_pop), c);
    @(negedge clk);
    chk_out(c, at, hu); // R5 stop at zero-uop side entry

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule